// File: doc/BRIEF.md
# Sixteen-Bit Multicycle Processor with Program Counter in the Register File

This block is a compact multicycle processor core for a 16-bit word machine. It has sixteen general registers, and register 0 serves as the program counter. All sixteen registers sit in one register file with a single address port. Writes happen on the clock edge and reads are combinational, so in one cycle the core can read a register and overwrite that same register. One temporary register holds a value from one cycle to the next. A single ALU does every piece of arithmetic, including stepping the program counter.

Instructions come from a word-addressed memory whose read data is combinational. Writes to that memory are sampled on the rising clock edge. Each instruction is fetched into an instruction register and then executed in one of four formats:
- an operate format, which is an ALU operation with an optional skip of the next word and optional write-back;
- a load;
- a store;
- a load-address.

The load, store and load-address formats all compute their address as a base register plus a signed 6-bit offset. Jumps are ordinary writes to register 0. Taking a load-address into register 0 gives a relative branch in either direction. Loading register 0 from the word after the instruction gives an absolute jump.

Top module: `wordcpu`

## Requirements
- R1: Instruction fields are laid out as follows.
  - Bits 15:14 select the format: 00 operate, 01 load, 10 store, 11 load-address.
  - Bits 13:10 name the destination or source register A.
  - Bits 9:6 name the base or operand register B.
  - In operate, bits 5:3 are the function, bits 2:1 the skip code and bit 0 the write-back flag.
  - In the other formats, bits 5:0 are the offset.
- R2: Operate computes a function of a = R[A] and b = R[B], selected by the function code: 0 a+b, 1 a−b, 2 b−a, 3 a AND b, 4 a OR b, 5 a XOR b, 6 and 7 pass b.
- R3: The skip code selects when the next word is skipped:
  - 00: never;
  - 01: when the result has bit 15 set;
  - 10: when the result is zero;
  - 11: when the result is nonzero with bit 15 clear.

  A taken skip adds one to register 0.
- R4: The operate result is written to R[A] only when the write-back flag is 1. Otherwise R[A] keeps its value.
- R5: The effective address is R[B] plus the offset, sign-extended from 6 bits (−32 to +31).
  - Load writes memory[ea] into R[A].
  - Store writes R[A] to memory[ea].
  - Load-address writes ea into R[A].
- R6: Register 0 holds the address of the next word to fetch. It is incremented before execution starts, so any instruction that reads register 0 sees the address after itself. Load with A = B = 0 and offset 0 therefore jumps to the address held in the following word. A load-address into register 0 with a negative offset branches backward.
- R7: Timing from reset release:
  - Fetch takes 2 cycles.
  - An operate instruction then takes 3 cycles, whether or not it skips.
  - Load, store and load-address take 2 cycles.
  - The memory write strobe is high only in the second execute cycle of a store.
- R8: While reset is high at a clock edge, all registers are cleared and a fetch is started. After reset, the first fetch is from address 0 with the write strobe low.
- R9: Memory read data is taken in the same cycle the address is presented. A write presents address, data and a strobe for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bench targets the edges of the skip logic:
- A result of 0x8000 must count as negative. A design that tested positive as "nonzero" would skip on it.
- A zero result must not count as positive.
- A subtraction that wraps negative must skip on the negative code.

A store with the write-back flag clear catches a core that writes back unconditionally. The cycle at which the first memory write appears catches an operate that takes the wrong number of cycles, or a skip that is lost.

The absolute-jump and backward-loop programs exercise the two offset rules. A core that increments register 0 after execution, or that zero-extends the offset, ends up at the wrong address and leaves a wrong count in memory.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    S_FETCH = 3'd0,
    S_INCPC = 3'd1,
    S_EX1   = 3'd2,
    S_EX2   = 3'd3,
    S_EX3   = 3'd4
  } state_t;

  localparam logic [1:0] FMT_OPR = 2'b00;
  localparam logic [1:0] FMT_LD  = 2'b01;
  localparam logic [1:0] FMT_ST  = 2'b10;
  localparam logic [1:0] FMT_LA  = 2'b11;

  localparam logic [2:0] FN_ADD  = 3'd0;
  localparam logic [2:0] FN_AMB  = 3'd1;
  localparam logic [2:0] FN_BMA  = 3'd2;
  localparam logic [2:0] FN_AND  = 3'd3;
  localparam logic [2:0] FN_OR   = 3'd4;
  localparam logic [2:0] FN_XOR  = 3'd5;

  function automatic logic skip_hit(input logic [1:0] code, input logic neg, input logic zero);
    case (code)
      2'b01:   return neg;
      2'b10:   return zero;
      2'b11:   return !neg && !zero;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wc_alu.sv
module wc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         neg,
  output logic         zero
);
  import wc_pkg::*;

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_AMB:  y = a - b;
      FN_BMA:  y = b - a;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end

  assign neg  = y[W-1];
  assign zero = (y == '0);
endmodule

// File: rtl/wc_regfile.sv
module wc_regfile #(
  parameter int W    = 16,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata = regs[addr];

  // R8: one edge after a write, the same location reads back the written value
  a_r8_write_visible: assert property (@(posedge clk) disable iff (rst)
    we |=> (($past(addr) != addr) || (rdata == $past(wdata))));
endmodule

// File: rtl/wc_seq.sv
module wc_seq (
  input  logic            clk,
  input  logic            rst,
  input  logic            is_opr,
  output wc_pkg::state_t  state
);
  import wc_pkg::*;

  state_t nxt;

  always_comb begin
    case (state)
      S_FETCH: nxt = S_INCPC;
      S_INCPC: nxt = S_EX1;
      S_EX1:   nxt = S_EX2;
      S_EX2:   nxt = is_opr ? S_EX3 : S_FETCH;
      default: nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  a_r7_fetch_two_cycles: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_INCPC));
  a_r7_mem_fmt_returns: assert property (@(posedge clk) disable iff (rst)
    (state == S_EX2 && !is_opr) |=> (state == S_FETCH));
  a_r7_third_cycle_ends: assert property (@(posedge clk) disable iff (rst)
    (state == S_EX3) |=> (state == S_FETCH));
endmodule

// File: rtl/wordcpu.sv
module wordcpu #(
  parameter int W    = 16,
  parameter int NREG = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_we
);
  import wc_pkg::*;

  localparam int RA    = $clog2(NREG);
  localparam int LOW_W = W - 2 - 2 * RA;
  localparam int R1_LO = W - 2 - RA;
  localparam int R2_LO = LOW_W;

  state_t          state;
  logic [W-1:0]    ir;
  logic [W-1:0]    tmp;
  logic            skip_q;

  logic [RA-1:0]   rf_addr;
  logic            rf_we;
  logic [W-1:0]    rf_wd;
  logic [W-1:0]    rf_rd;

  logic [W-1:0]    alu_b;
  logic [2:0]      alu_fn;
  logic [W-1:0]    alu_y;
  logic            alu_neg;
  logic            alu_zero;

  logic [1:0]      f_fmt;
  logic [RA-1:0]   f_ra;
  logic [RA-1:0]   f_rb;
  logic [2:0]      f_fn;
  logic [1:0]      f_sk;
  logic            f_wb;
  logic [W-1:0]    f_off;

  assign f_fmt = ir[W-1 -: 2];
  assign f_ra  = ir[R1_LO +: RA];
  assign f_rb  = ir[R2_LO +: RA];
  assign f_fn  = ir[LOW_W-1 -: 3];
  assign f_sk  = ir[2:1];
  assign f_wb  = ir[0];
  assign f_off = {{(W-LOW_W){ir[LOW_W-1]}}, ir[LOW_W-1:0]};

  wc_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .is_opr (f_fmt == FMT_OPR),
    .state  (state)
  );

  wc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .addr  (rf_addr),
    .we    (rf_we),
    .wdata (rf_wd),
    .rdata (rf_rd)
  );

  wc_alu #(.W(W)) u_alu (
    .a    (rf_rd),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .neg  (alu_neg),
    .zero (alu_zero)
  );

  always_comb begin
    rf_addr   = '0;
    rf_we     = 1'b0;
    rf_wd     = alu_y;
    alu_b     = W'(1);
    alu_fn    = FN_ADD;
    mem_addr  = rf_rd;
    mem_wdata = rf_rd;
    mem_we    = 1'b0;
    case (state)
      S_FETCH: rf_addr = '0;
      S_INCPC: begin
        rf_addr = '0;
        rf_we   = 1'b1;
      end
      S_EX1: begin
        rf_addr = f_rb;
        alu_b   = f_off;
      end
      S_EX2: begin
        rf_addr = f_ra;
        case (f_fmt)
          FMT_OPR: begin
            alu_b  = tmp;
            alu_fn = f_fn;
            rf_we  = f_wb;
          end
          FMT_LD: begin
            mem_addr = tmp;
            rf_wd    = mem_rdata;
            rf_we    = 1'b1;
          end
          FMT_ST: begin
            mem_addr = tmp;
            mem_we   = 1'b1;
          end
          default: begin
            rf_wd = tmp;
            rf_we = 1'b1;
          end
        endcase
      end
      default: begin
        rf_addr = '0;
        rf_we   = skip_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir     <= '0;
      tmp    <= '0;
      skip_q <= 1'b0;
    end else begin
      if (state == S_FETCH) ir <= mem_rdata;
      if (state == S_EX1)   tmp <= (f_fmt == FMT_OPR) ? rf_rd : alu_y;
      if (state == S_EX2)   skip_q <= (f_fmt == FMT_OPR) && skip_hit(f_sk, alu_neg, alu_zero);
    end
  end

  // R8: first cycle after reset fetches from address zero without writing
  a_r8_reset_fetch_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && !mem_we));
  // R9: the word present during fetch becomes the instruction
  a_r9_ir_capture: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (ir == $past(mem_rdata)));
  // R3: the fetch after an operate starts one word further when the skip was taken
  a_r3_skip_advances_pc: assert property (@(posedge clk) disable iff (rst)
    (state == S_EX3) |=> (mem_addr == $past(rf_rd) + ($past(skip_q) ? W'(1) : W'(0))));
  // R7: a write strobe is always preceded by the address-forming cycle
  a_r7_write_after_ea: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(state) == S_EX1));
endmodule

// File: tb/wordcpu_bench.sv
`timescale 1ns/1ps
module wordcpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic        ld_we = 1'b0;
  logic [5:0]  ld_a  = '0;
  logic [15:0] ld_d  = '0;
  logic [15:0] mem [64];
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  wordcpu u_wordcpu (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we)
  );

  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) begin
    if (rst && ld_we)   mem[ld_a] <= ld_d;
    else if (mem_we)    mem[mem_addr[5:0]] <= mem_wdata;
  end

  // Vector: {a, b, fn, skip code, write-back, expected word, expect no-skip}
  localparam logic [54:0] VEC [10] = '{
    {16'h0005, 16'h0003, 3'd0, 2'd0, 1'b1, 16'h0008, 1'b1},
    {16'h0005, 16'h0003, 3'd1, 2'd1, 1'b1, 16'h0002, 1'b1},
    {16'h0003, 16'h0005, 3'd1, 2'd1, 1'b1, 16'hFFFE, 1'b0},
    {16'h0003, 16'h0005, 3'd2, 2'd3, 1'b0, 16'h0003, 1'b0},
    {16'h00F0, 16'h0F0F, 3'd3, 2'd2, 1'b1, 16'h0000, 1'b0},
    {16'h00F0, 16'h0F00, 3'd4, 2'd2, 1'b1, 16'h0FF0, 1'b1},
    {16'hAAAA, 16'hAAAA, 3'd5, 2'd3, 1'b1, 16'h0000, 1'b1},
    {16'h8000, 16'h0001, 3'd0, 2'd3, 1'b1, 16'h8001, 1'b1},
    {16'h7FFF, 16'h0001, 3'd0, 2'd1, 1'b1, 16'h8000, 1'b0},
    {16'h1234, 16'h5678, 3'd6, 2'd0, 1'b1, 16'h5678, 1'b1}
  };

  function automatic logic [15:0] e_op(int fn, int ra, int rb, int sk, int wb);
    return {2'b00, 4'(ra), 4'(rb), 3'(fn), 2'(sk), 1'(wb)};
  endfunction
  function automatic logic [15:0] e_m(logic [1:0] fmt, int ra, int rb, int off);
    return {fmt, 4'(ra), 4'(rb), 6'(off)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [15:0] d);
    @(negedge clk);
    ld_a = 6'(a); ld_d = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic wipe();
    rst = 1'b1;
    for (int i = 0; i < 64; i++) poke(i, 16'h0000);
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state seen at the ports
    repeat (3) @(negedge clk);
    chk("R8 reset addr", mem_addr, 16'h0000);
    chk("R8 reset strobe", {15'd0, mem_we}, 16'h0000);

    // Table walk: R1 R2 R3 R4 R5 R7 R9
    for (int v = 0; v < 10; v++) begin
      logic [54:0] t;
      int cyc;
      t = VEC[v];
      wipe();
      poke(0, e_m(2'b01, 1, 3, 20));
      poke(1, e_m(2'b01, 2, 3, 21));
      poke(2, e_op(int'(t[22:20]), 1, 2, int'(t[19:18]), int'(t[17])));
      poke(3, e_m(2'b11, 4, 3, 1));
      poke(4, e_m(2'b10, 1, 3, 22));
      poke(5, e_m(2'b10, 4, 3, 23));
      poke(6, e_m(2'b11, 0, 0, -1));
      poke(20, t[54:39]);
      poke(21, t[38:23]);
      release_rst();
      cyc = 0;
      while (!mem_we && cyc < 60) begin
        @(negedge clk);
        cyc++;
      end
      chk("R7 first store cycle", 16'(cyc), t[0] ? 16'd20 : 16'd16);
      repeat (40) @(negedge clk);
      chk("R2 R4 result word", mem[22], t[16:1]);
      chk("R3 skip marker", mem[23], {15'd0, t[0]});
    end

    // R8: reset forces a fetch from 0 again after a run
    rst = 1'b1;
    @(negedge clk);
    chk("R8 re-reset addr", mem_addr, 16'h0000);
    chk("R8 re-reset strobe", {15'd0, mem_we}, 16'h0000);

    // R6: absolute jump through the following word, R0 as operand sees incremented PC
    wipe();
    poke(0, e_m(2'b01, 0, 0, 0));
    poke(1, 16'd10);
    poke(2, e_m(2'b11, 5, 3, 9));
    poke(3, e_m(2'b10, 5, 3, 25));
    poke(10, e_op(0, 7, 0, 0, 1));
    poke(11, e_m(2'b10, 7, 3, 24));
    poke(12, e_m(2'b11, 0, 0, -1));
    release_rst();
    repeat (80) @(negedge clk);
    chk("R6 jump target reached", mem[24], 16'd11);
    chk("R6 skipped-over code idle", mem[25], 16'd0);

    // R5 R6: backward branch by negative offset, loop count at a fixed cycle
    wipe();
    poke(0, e_m(2'b11, 6, 6, 1));
    poke(1, e_m(2'b10, 6, 3, 26));
    poke(2, e_m(2'b11, 0, 0, -3));
    release_rst();
    repeat (60) @(negedge clk);
    chk("R5 backward loop count", mem[26], 16'd5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule